// File: doc/BRIEF.md
# Serial Receive Path with Line Status

This block turns an asynchronous serial input into characters and reports line conditions to a processor. A one-cycle baud strobe at sixteen times the bit rate drives a sampling state machine. It checks the start bit at mid-bit and samples each data bit, the optional parity bit and the stop bit at the centre of the bit. Characters are 5 to 8 bits long and arrive least significant bit first.

Received characters go to one of two places. The first is a single holding register. The second is a receive queue in which every entry keeps its own parity, framing and break tags. A small register port gives the processor the received character, a configuration register and a line status register. Each error flag in the line status register clears when that register is read. Any error raises a line status interrupt, provided that interrupt is enabled.

A write to the data address is passed to the transmitter. The transmitter returns a one-cycle pulse when its holding storage becomes empty.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset the line status register (address 2) reads 0x20, the configuration register (address 1) reads 0x06, and the interrupt is low.
- R2: The configuration register has these fields: bit 0 selects the receive queue, bits 2:1 give the data length minus 5, bit 3 enables parity, bit 4 selects even parity (1) or odd parity (0), and bit 5 enables the interrupt. A character is sampled LSB first and is read at address 0. Status bit 0 (data ready) is 1 while at least one character is stored, and drops when the storage is empty after a read.
- R3: In holding-register mode, a character that completes while the previous one is still unread replaces the previous one and sets status bit 1 (overrun).
- R4: In queue mode, with all 16 entries full, a further completed character is dropped, the queue contents stay unchanged, and status bit 1 sets at once.
- R5: Status bit 2 (parity error) sets when parity is enabled and the XOR of the data bits and the parity bit is 1 under even parity, or 0 under odd parity.
- R6: Status bit 3 (framing error) sets when the stop bit is sampled low.
- R7: After a framing error, the low stop bit is treated as the start bit of the next character. It is checked once more, and the data bits that follow are then received without a new start bit.
- R8: When every sample from the start bit through the stop bit is low, status bit 4 (break) sets. Exactly one all-zero character is stored. Reception resumes only after the line returns high and a new start bit arrives.
- R9: In queue mode, the parity, framing and break flags shown in the status register belong to the character at the head of the queue. They appear only once that character reaches the head.
- R10: A read of the line status register clears status bits 1 to 4. Bits 0 and 5 are not affected.
- R11: The interrupt output equals the enable bit ANDed with the OR of status bits 1 to 4.
- R12: Status bit 5 (transmit holding empty) clears on a write to address 0 and sets on the transmitter's empty pulse. The write is forwarded as a one-cycle strobe carrying the data.
- R13: A low level that has returned high by the start bit's mid-bit sample is ignored, and no character is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxIn | input | 1 | Serial input; idle high |
| regAddr | input | 2 | Register address: 0 data, 1 configuration, 2 line status |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; triggers the read side effects |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, valid in the same cycle |
| txNowEmpty | input | 1 | Transmitter pulse: holding storage became empty |
| txWrStb | output | 1 | Write strobe forwarded to the transmitter |
| txWrData | output | 8 | Data forwarded to the transmitter |
| irqLineStat | output | 1 | Receiver line status interrupt |

## Verification
On every cycle the assertions check four things: the queue never exceeds its depth, a full queue sets overrun and keeps its contents, a status read clears overrun, and the transmit-empty flag drops after a data write. They also check that the interrupt cannot fire while it is disabled. Sampling position, resynchronisation on a low stop bit, and the single zero character stored for a break can only be shown by bench scenarios that drive whole frames. The same holds for the rejection of a short start glitch and for flags that appear only when their character reaches the queue head. Those scenarios compare every character and status value against a behavioural queue model.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_LSR  = 2'd2;

  typedef struct packed {
    logic       fifoEn;
    logic [1:0] wordLen;
    logic       parEn;
    logic       parEven;
    logic       lsiEn;
  } rxCfg_t;

  // strobes from the sampling control to the datapath
  typedef struct packed {
    logic capData;
    logic capParity;
    logic bitVal;
    logic frameDone;
    logic frameErr;
    logic breakHit;
  } rxStrobe_t;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxIn,
  input  logic [1:0] wordLen,
  input  logic       parEn,
  output rxStrobe_t  strobe
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BREAK
  } rxState_t;

  rxState_t        state;
  logic            rxMeta, rxSync;
  logic [CW-1:0]   tickCnt;
  logic [2:0]      bitIdx;
  logic            allZero;
  logic [2:0]      lastIdx;
  logic            atEnd;

  assign lastIdx = 3'd4 + {1'b0, wordLen};
  assign atEnd   = baudTick && (tickCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.bitVal    = rxSync;
    strobe.capData   = atEnd && (state == S_DATA);
    strobe.capParity = atEnd && (state == S_PAR);
    strobe.frameDone = atEnd && (state == S_STOP);
    strobe.frameErr  = strobe.frameDone && !rxSync && !allZero;
    strobe.breakHit  = strobe.frameDone && !rxSync && allZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      allZero <= 1'b0;
    end else if (baudTick) begin
      unique case (state)
        S_IDLE: begin
          if (!rxSync) begin
            state   <= S_START;
            tickCnt <= '0;
          end
        end
        S_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            allZero <= 1'b1;
            state   <= rxSync ? S_IDLE : S_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            if (rxSync) allZero <= 1'b0;
            if (bitIdx == lastIdx) state <= parEn ? S_PAR : S_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            if (rxSync) allZero <= 1'b0;
            state <= S_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (tickCnt == LAST_CNT) begin
            if (rxSync) begin
              state <= S_IDLE;
            end else if (allZero) begin
              state <= S_BREAK;
            end else begin
              // low stop bit becomes the next start bit: check it once more
              state   <= S_START;
              tickCnt <= MID_CNT - 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_BREAK: begin
          if (rxSync) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BREAK_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BREAK && !rxSync) |=> (state == S_BREAK)); // R8
  AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_START && baudTick && tickCnt == MID_CNT && rxSync) |=> (state == S_IDLE)); // R13
  AST_FRAME_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.frameErr && strobe.breakHit)); // R6

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16   // power of two
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strobe,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       txNowEmpty,
  output logic       txWrStb,
  output logic [7:0] txWrData,
  output rxCfg_t     cfg,
  output logic       irqLineStat
);

  localparam int PW   = $clog2(FIFO_DEPTH);
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(FIFO_DEPTH);

  logic [7:0]      shReg;
  logic            parBit;
  rxEntry_t        mem [FIFO_DEPTH];
  logic [PW-1:0]   wrPtr, rdPtr;
  logic [CNTW-1:0] count;
  rxEntry_t        hold;
  logic            holdValid;
  logic            headSeen;
  logic [2:0]      errSticky;
  logic            ovr;
  logic            thre;

  logic            lsrRead, rbrRead, cfgWr, thrWrite, flush;
  logic            full, push, pop, loadHold, ovrEvt, headChange;
  logic [2:0]      shAmt;
  logic [7:0]      newData;
  logic            parErr;
  rxEntry_t        newEntry, headEntry;
  logic            headValid;
  logic [2:0]      errBits;

  assign lsrRead  = regRd && (regAddr == ADDR_LSR);
  assign rbrRead  = regRd && (regAddr == ADDR_DATA);
  assign cfgWr    = regWr && (regAddr == ADDR_CFG);
  assign thrWrite = regWr && (regAddr == ADDR_DATA);
  assign flush    = cfgWr && (regWdata[0] != cfg.fifoEn);

  // character assembly
  assign shAmt    = 3'd3 - {1'b0, cfg.wordLen};
  assign newData  = shReg >> shAmt;
  assign parErr   = cfg.parEn && !strobe.breakHit &&
                    ((^newData ^ parBit) == cfg.parEven);
  assign newEntry = '{brk: strobe.breakHit, frm: strobe.frameErr,
                      par: parErr, data: newData};

  // storage control
  assign full       = (count == FULL_CNT);
  assign push       = strobe.frameDone && cfg.fifoEn && !full && !flush;
  assign pop        = rbrRead && cfg.fifoEn && (count != '0) && !flush;
  assign loadHold   = strobe.frameDone && !cfg.fifoEn && !flush;
  assign ovrEvt     = strobe.frameDone &&
                      (cfg.fifoEn ? full : (holdValid && !rbrRead));
  assign headChange = pop || (push && count == '0) || loadHold;

  assign headEntry  = cfg.fifoEn ? mem[rdPtr] : hold;
  assign headValid  = cfg.fifoEn ? (count != '0) : holdValid;
  assign errBits    = cfg.fifoEn ?
                      ((headValid && !headSeen) ? {headEntry.brk, headEntry.frm, headEntry.par} : 3'b000)
                      : errSticky;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      parBit    <= 1'b0;
      cfg       <= '{fifoEn: 1'b0, wordLen: 2'd3, parEn: 1'b0, parEven: 1'b0, lsiEn: 1'b0};
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      hold      <= '0;
      holdValid <= 1'b0;
      headSeen  <= 1'b0;
      errSticky <= '0;
      ovr       <= 1'b0;
      thre      <= 1'b1;
    end else begin
      if (strobe.capData)   shReg  <= {strobe.bitVal, shReg[7:1]};
      if (strobe.capParity) parBit <= strobe.bitVal;

      if (cfgWr) begin
        cfg.fifoEn  <= regWdata[0];
        cfg.wordLen <= regWdata[2:1];
        cfg.parEn   <= regWdata[3];
        cfg.parEven <= regWdata[4];
        cfg.lsiEn   <= regWdata[5];
      end

      if (flush) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        count     <= '0;
        holdValid <= 1'b0;
      end else begin
        if (push) wrPtr <= wrPtr + 1'b1;
        if (pop)  rdPtr <= rdPtr + 1'b1;
        if (push && !pop)      count <= count + 1'b1;
        else if (!push && pop) count <= count - 1'b1;
        if (loadHold) begin
          hold      <= newEntry;
          holdValid <= 1'b1;
        end else if (rbrRead && !cfg.fifoEn) begin
          holdValid <= 1'b0;
        end
      end

      // head flags: hidden once reported, revealed again for a new head
      if (lsrRead)    headSeen <= 1'b1;
      if (headChange) headSeen <= 1'b0;

      if (loadHold)
        errSticky <= (lsrRead ? 3'b000 : errSticky) |
                     {newEntry.brk, newEntry.frm, newEntry.par};
      else if (lsrRead)
        errSticky <= 3'b000;

      if (ovrEvt)       ovr <= 1'b1;
      else if (lsrRead) ovr <= 1'b0;

      if (thrWrite)        thre <= 1'b0;
      else if (txNowEmpty) thre <= 1'b1;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_DATA: regRdata = headValid ? headEntry.data : 8'h00;
      ADDR_CFG:  regRdata = {2'b00, cfg.lsiEn, cfg.parEven, cfg.parEn, cfg.wordLen, cfg.fifoEn};
      ADDR_LSR:  regRdata = {2'b00, thre, errBits, ovr, headValid};
      default:   regRdata = 8'h00;
    endcase
  end

  assign txWrStb     = thrWrite;
  assign txWrData    = regWdata;
  assign irqLineStat = cfg.lsiEn && (ovr || (errBits != 3'b000));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R4
  AST_FULL_SETS_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && cfg.fifoEn && full) |=> ovr); // R4
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && cfg.fifoEn && full && !rbrRead && !cfgWr) |=> (count == FULL_CNT)); // R4
  AST_LSR_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !strobe.frameDone) |=> !ovr); // R10
  AST_THRE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> !thre); // R12
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqLineStat |-> cfg.lsiEn); // R11

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxIn,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       txNowEmpty,
  output logic       txWrStb,
  output logic [7:0] txWrData,
  output logic       irqLineStat
);

  rxStrobe_t strobe;
  rxCfg_t    cfg;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .rxIn     (rxIn),
    .wordLen  (cfg.wordLen),
    .parEn    (cfg.parEn),
    .strobe   (strobe)
  );

  uart_rx_dp #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regAddr     (regAddr),
    .regWr       (regWr),
    .regRd       (regRd),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .txNowEmpty  (txNowEmpty),
    .txWrStb     (txWrStb),
    .txWrData    (txWrData),
    .cfg         (cfg),
    .irqLineStat (irqLineStat)
  );

endmodule

// File: tb/uart_rx_lsr_tb.sv
module uart_rx_lsr_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxIn = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       txNowEmpty = 1'b0;
  logic       txWrStb;
  logic [7:0] txWrData;
  logic       irqLineStat;

  int testCount = 0;
  int failCount = 0;
  int divCnt = 0;
  logic [7:0] expQ[$];   // behavioural model of the receive queue

  uart_rx_lsr dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .txNowEmpty(txNowEmpty), .txWrStb(txWrStb),
    .txWrData(txWrData), .irqLineStat(irqLineStat)
  );

  always #2.5 clk = ~clk;

  // 16x tick every 4 clocks: 64 clocks per bit
  always @(negedge clk) begin
    divCnt   = (divCnt + 1) % 4;
    baudTick = (divCnt == 0);
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d,
                          output logic stb, output logic [7:0] fwd);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    #1 stb = txWrStb; fwd = txWrData;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setCfg(input logic [7:0] d);
    logic s; logic [7:0] f;
    cpuWrite(2'd1, d, s, f);
  endtask

  task automatic sendBit(input logic b);
    rxIn = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input int nb, input bit withPar,
                          input logic parVal, input logic stopVal);
    sendBit(1'b0);
    for (int i = 0; i < nb; i++) sendBit(d[i]);
    if (withPar) sendBit(parVal);
    sendBit(stopVal);
  endtask

  task automatic expectLsr(input string req, input logic [7:0] exp);
    logic [7:0] v;
    cpuRead(2'd2, v);
    check(req, v, exp);
  endtask

  task automatic expectData(input string req);
    logic [7:0] v, e;
    e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
    cpuRead(2'd0, v);
    check(req, v, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    logic       s;
    logic [7:0] f;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'd0, irqLineStat}, 8'h00);
    expectLsr("R1 lsr", 8'h20);
    cpuRead(2'd1, v);
    check("R1 cfg", v, 8'h06);

    // R2 8-bit character, holding register
    sendChar(8'hA5, 8, 0, 1'b0, 1'b1); expQ.push_back(8'hA5);
    expectLsr("R2 ready", 8'h21);
    expectData("R2 data 8bit");
    expectLsr("R2 empty", 8'h20);

    // R2 5-bit character
    setCfg(8'h00);
    sendChar(8'h15, 5, 0, 1'b0, 1'b1); expQ.push_back(8'h15);
    expectData("R2 data 5bit");

    // R3 overrun in holding mode, R10 clear
    setCfg(8'h06);
    sendChar(8'h11, 8, 0, 1'b0, 1'b1);
    sendChar(8'h22, 8, 0, 1'b0, 1'b1); expQ.push_back(8'h22);
    expectLsr("R3 overrun", 8'h23);
    expectLsr("R10 overrun cleared", 8'h21);
    expectData("R3 newest kept");

    // R5 parity, R11 interrupt, even then odd
    setCfg(8'h3E);
    sendChar(8'h03, 8, 1, 1'b0, 1'b1); expQ.push_back(8'h03);
    check("R11 no irq", {7'd0, irqLineStat}, 8'h00);
    expectLsr("R5 good even", 8'h21);
    expectData("R5 data");
    sendChar(8'h01, 8, 1, 1'b0, 1'b1); expQ.push_back(8'h01);
    check("R11 irq", {7'd0, irqLineStat}, 8'h01);
    expectLsr("R5 bad even", 8'h25);
    expectLsr("R10 parity cleared", 8'h21);
    check("R11 irq cleared", {7'd0, irqLineStat}, 8'h00);
    expectData("R5 data bad");
    setCfg(8'h2E);
    sendChar(8'h01, 8, 1, 1'b0, 1'b1); expQ.push_back(8'h01);
    expectLsr("R5 good odd", 8'h21);
    expectData("R5 data odd");

    // R6 framing error, R7 resync on low stop bit (queue mode)
    setCfg(8'h07);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(v_bit(8'h3C, i));
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(v_bit(8'h5A, i));
    sendBit(1'b1);
    sendBit(1'b1);
    expQ.push_back(8'h3C); expQ.push_back(8'h5A);
    expectLsr("R6 framing", 8'h29);
    expectLsr("R10 framing cleared", 8'h21);
    expectData("R6 data");
    expectLsr("R7 next clean", 8'h21);
    expectData("R7 resync data");
    expectLsr("R7 empty", 8'h20);

    // R9 flags revealed at the head only
    setCfg(8'h1F);
    sendChar(8'h10, 8, 1, 1'b1, 1'b1); expQ.push_back(8'h10);
    sendChar(8'h20, 8, 1, 1'b0, 1'b1); expQ.push_back(8'h20);
    expectLsr("R9 head clean", 8'h21);
    expectData("R9 data1");
    expectLsr("R9 tagged head", 8'h25);
    expectData("R9 data2");
    expectLsr("R9 empty", 8'h20);

    // R4 queue overrun
    setCfg(8'h07);
    for (int i = 0; i < 17; i++) begin
      sendChar(8'(8'h40 + i), 8, 0, 1'b0, 1'b1);
      if (i < 16) expQ.push_back(8'(8'h40 + i));
    end
    expectLsr("R4 overrun", 8'h23);
    for (int i = 0; i < 16; i++) expectData("R4 contents");
    expectLsr("R4 drained", 8'h20);

    // R8 break
    rxIn = 1'b0;
    repeat (20 * 64) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * 64) @(negedge clk);
    expQ.push_back(8'h00);
    expectLsr("R8 break", 8'h31);
    expectData("R8 zero char");
    expectLsr("R8 single char", 8'h20);

    // R13 short glitch ignored
    rxIn = 1'b0;
    repeat (16) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * 64) @(negedge clk);
    expectLsr("R13 glitch", 8'h20);
    sendChar(8'h77, 8, 0, 1'b0, 1'b1); expQ.push_back(8'h77);
    expectData("R13 after glitch");

    // R12 transmit holding empty
    cpuWrite(2'd0, 8'h99, s, f);
    check("R12 strobe", {7'd0, s}, 8'h01);
    check("R12 fwd data", f, 8'h99);
    expectLsr("R12 thre low", 8'h00);
    @(negedge clk); txNowEmpty = 1'b1;
    @(negedge clk); txNowEmpty = 1'b0;
    expectLsr("R12 thre high", 8'h20);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  function automatic logic v_bit(input logic [7:0] d, input int i);
    return d[i];
  endfunction

endmodule